// File: doc/BRIEF.md
# Configurable Macrocell Storage and Output Stage

This block is the back end of one programmable-logic cell. A selected data bit feeds a single storage bit. A mode field makes that bit behave as a D, toggle, JK or set/reset flip-flop, or as a level-sensitive latch. The cell clock comes from a global clock line or from a product term, and an optional product-term enable gates it. Clear and preset are selectable as well. From the stored bit and the combinational logic value, the block drives the pad data, the pad's tristate enable and the feedback bit that goes back into the logic array.

The whole stage runs on one system clock, `clk`. The cell clock, the enable and the clear and preset lines are ordinary inputs that are sampled on each `clk` edge. A cell clock edge means the selected clock was low at one sample and high at the next. A clear or preset acts on the first `clk` edge where it is seen, whatever the cell clock is doing. The pad data, enable and feedback are muxes over the stored bit and the present inputs. A change in the stored bit therefore shows at the outputs after the same `clk` edge that makes it. The configuration inputs are meant to be held static while the cell runs.

Top module: `mcr_macrocell_reg`

## Requirements
- R1: In D mode (`cfg_mode`=0) a cell clock edge loads the selected data bit into the stored bit. `cfg_dsrc` selects the data bit: 0 takes `xor_in`, 1 takes `pt_d`, 2 takes `pin_in`, and 3 takes `xor_in`.
- R2: In toggle mode (`cfg_mode`=1) a cell clock edge inverts the stored bit when the selected data bit is 1. When the data bit is 0 the stored bit keeps its value.
- R3: In JK mode (`cfg_mode`=2) `pt_a` is J and `pt_b` is K. On a cell clock edge, 00 holds, 10 sets, 01 clears and 11 toggles.
- R4: In set/reset mode (`cfg_mode`=3) `pt_a` is S and `pt_b` is R. On a cell clock edge, 10 sets and 01 clears, while 00 and 11 both hold.
- R5: In latch mode (`cfg_mode`=4) the stored bit takes the selected data bit on every `clk` edge where the gated cell clock is high. While the cell clock is low the stored bit holds. Modes 5 to 7 hold the bit at all times.
- R6: In the flip-flop modes (0 to 3) the stored bit changes only on a cell clock edge, which is a sampled low-to-high transition. A clock that stays high or falls leaves the bit alone.
- R7: `cfg_clk_pt`=0 takes the cell clock from `gclk`, and `cfg_clk_pt`=1 takes it from `pt_clk`.
- R8: When `cfg_clk_pt`=0 and `cfg_ce_en`=1, a low `pt_ce` makes the cell ignore every cell clock edge and keeps the latch closed. `pt_ce` has no effect when `cfg_clk_pt`=1 or when `cfg_ce_en`=0.
- R9: `cfg_ar` selects the clear source: 0 is none, 1 is `gclr`, 2 is `pt_ar`, and 3 is either of the two. `cfg_ap_en`=1 turns on `pt_ap` as the preset. A clear forces the stored bit to 0 at the next `clk` edge, and a preset forces it to 1 there. When both are active, the clear wins.
- R10: The pad data `pin_out` is the stored bit when `cfg_out_reg`=1 and `xor_in` when it is 0. The feedback `fb_out` makes the same choice through `cfg_fb_reg`, independently of `cfg_out_reg`.
- R11: `cfg_oe` sets the pad enable `pin_oe`: 0 gives 1, 1 gives 0, 2 gives `goe0`, 3 gives `goe1`, 4 gives `pt_oe`, and 5 to 7 give 0.
- R12: While `rst` is high, a `clk` edge clears the stored bit and the remembered cell clock sample to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Storage behaviour |
| cfg_dsrc | input | 2 | Data bit source |
| cfg_clk_pt | input | 1 | Cell clock from product term |
| cfg_ce_en | input | 1 | Use product-term clock enable |
| cfg_ar | input | 2 | Clear source select |
| cfg_ap_en | input | 1 | Preset enable |
| cfg_out_reg | input | 1 | Pad data from stored bit |
| cfg_fb_reg | input | 1 | Feedback from stored bit |
| cfg_oe | input | 3 | Pad enable select |
| xor_in | input | 1 | Combinational logic result |
| pt_d | input | 1 | Product-term data |
| pin_in | input | 1 | Pad input value |
| pt_a | input | 1 | J or S product term |
| pt_b | input | 1 | K or R product term |
| gclk | input | 1 | Global cell clock |
| pt_clk | input | 1 | Product-term cell clock |
| pt_ce | input | 1 | Product-term clock enable |
| gclr | input | 1 | Global clear |
| pt_ar | input | 1 | Product-term clear |
| pt_ap | input | 1 | Product-term preset |
| goe0 | input | 1 | Global output enable 0 |
| goe1 | input | 1 | Global output enable 1 |
| pt_oe | input | 1 | Product-term output enable |
| pin_out | output | 1 | Pad data |
| pin_oe | output | 1 | Pad tristate enable |
| fb_out | output | 1 | Feedback to the logic array |

## Verification
The stored bit is updated from the inputs sampled at a `clk` edge. It is visible at `pin_out` and `fb_out`, in registered selection, right after that edge. The combinational selections and `pin_oe` follow the inputs present in the same cycle. The bench drives new inputs 5 ns after each rising edge and compares all three outputs against its reference model. It makes that comparison 5 ns after the next rising edge, by which time the model has applied that edge, so each edge-triggered result is checked exactly one edge after its stimulus. Edge detection needs a low sample before a high one, so a cell clock already high out of reset counts as an edge on the first cycle; the model does the same.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    CLR_NONE   = 2'd0,
    CLR_GLOBAL = 2'd1,
    CLR_PT     = 2'd2,
    CLR_EITHER = 2'd3
  } clr_sel_e;

  typedef enum logic [2:0] {
    OE_ON     = 3'd0,
    OE_OFF    = 3'd1,
    OE_GLOB0  = 3'd2,
    OE_GLOB1  = 3'd3,
    OE_PTERM  = 3'd4
  } oe_sel_e;

  localparam logic [1:0] DSRC_PT  = 2'd1;
  localparam logic [1:0] DSRC_PIN = 2'd2;

  typedef struct packed {
    logic tick;   // qualified cell clock edge
    logic open;   // latch transparent
    logic clr;    // clear request
    logic set;    // preset request
  } ctl_t;

endpackage

// File: rtl/mcr_ctrl.sv
module mcr_ctrl
  import mcr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_clk_pt,
  input  logic     cfg_ce_en,
  input  clr_sel_e cfg_ar,
  input  logic     cfg_ap_en,
  input  logic     gclk,
  input  logic     pt_clk,
  input  logic     pt_ce,
  input  logic     gclr,
  input  logic     pt_ar,
  input  logic     pt_ap,
  output ctl_t     ctl
);

  logic cell_clk;
  logic clk_prev;
  logic gate_ok;
  logic clr_req;

  assign cell_clk = cfg_clk_pt ? pt_clk : gclk;
  // enable only qualifies the global clock path
  assign gate_ok  = cfg_clk_pt | ~cfg_ce_en | pt_ce;

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b0;
    else     clk_prev <= cell_clk;
  end

  always_comb begin
    unique case (cfg_ar)
      CLR_GLOBAL: clr_req = gclr;
      CLR_PT:     clr_req = pt_ar;
      CLR_EITHER: clr_req = gclr | pt_ar;
      default:    clr_req = 1'b0;
    endcase
  end

  always_comb begin
    ctl.tick = cell_clk & ~clk_prev & gate_ok;
    ctl.open = cell_clk & gate_ok;
    ctl.clr  = clr_req;
    ctl.set  = cfg_ap_en & pt_ap;
  end

endmodule

// File: rtl/mcr_store.sv
module mcr_store
  import mcr_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  d,
  input  logic  a,
  input  logic  b,
  input  ctl_t  ctl,
  output logic  q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    case (mode)
      MODE_D:  if (ctl.tick) q_nxt = d;
      MODE_T:  if (ctl.tick && d) q_nxt = ~q;
      MODE_JK: if (ctl.tick) begin
        case ({a, b})
          2'b10:   q_nxt = 1'b1;
          2'b01:   q_nxt = 1'b0;
          2'b11:   q_nxt = ~q;
          default: q_nxt = q;
        endcase
      end
      MODE_SR: if (ctl.tick) begin
        case ({a, b})
          2'b10:   q_nxt = 1'b1;
          2'b01:   q_nxt = 1'b0;
          default: q_nxt = q;
        endcase
      end
      MODE_LATCH: if (ctl.open) q_nxt = d;
      default: q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          q <= RST_VAL;
    else if (ctl.clr) q <= 1'b0;
    else if (ctl.set) q <= 1'b1;
    else              q <= q_nxt;
  end

endmodule

// File: rtl/mcr_out.sv
module mcr_out
  import mcr_pkg::*;
(
  input  logic    cfg_out_reg,
  input  logic    cfg_fb_reg,
  input  oe_sel_e cfg_oe,
  input  logic    q,
  input  logic    comb,
  input  logic    goe0,
  input  logic    goe1,
  input  logic    pt_oe,
  output logic    pin_out,
  output logic    pin_oe,
  output logic    fb_out
);

  assign pin_out = cfg_out_reg ? q : comb;
  assign fb_out  = cfg_fb_reg  ? q : comb;

  always_comb begin
    case (cfg_oe)
      OE_ON:    pin_oe = 1'b1;
      OE_GLOB0: pin_oe = goe0;
      OE_GLOB1: pin_oe = goe1;
      OE_PTERM: pin_oe = pt_oe;
      default:  pin_oe = 1'b0;
    endcase
  end

endmodule

// File: rtl/mcr_macrocell_reg.sv
module mcr_macrocell_reg
  import mcr_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cfg_mode,
  input  logic [1:0] cfg_dsrc,
  input  logic       cfg_clk_pt,
  input  logic       cfg_ce_en,
  input  logic [1:0] cfg_ar,
  input  logic       cfg_ap_en,
  input  logic       cfg_out_reg,
  input  logic       cfg_fb_reg,
  input  logic [2:0] cfg_oe,
  input  logic       xor_in,
  input  logic       pt_d,
  input  logic       pin_in,
  input  logic       pt_a,
  input  logic       pt_b,
  input  logic       gclk,
  input  logic       pt_clk,
  input  logic       pt_ce,
  input  logic       gclr,
  input  logic       pt_ar,
  input  logic       pt_ap,
  input  logic       goe0,
  input  logic       goe1,
  input  logic       pt_oe,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out
);

  ctl_t ctl;
  logic d_sel;
  logic q_r;

  always_comb begin
    case (cfg_dsrc)
      DSRC_PT:  d_sel = pt_d;
      DSRC_PIN: d_sel = pin_in;
      default:  d_sel = xor_in;
    endcase
  end

  mcr_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_clk_pt(cfg_clk_pt),
    .cfg_ce_en (cfg_ce_en),
    .cfg_ar    (clr_sel_e'(cfg_ar)),
    .cfg_ap_en (cfg_ap_en),
    .gclk      (gclk),
    .pt_clk    (pt_clk),
    .pt_ce     (pt_ce),
    .gclr      (gclr),
    .pt_ar     (pt_ar),
    .pt_ap     (pt_ap),
    .ctl       (ctl)
  );

  mcr_store #(.RST_VAL(RST_VAL)) u_store (
    .clk (clk),
    .rst (rst),
    .mode(mode_e'(cfg_mode)),
    .d   (d_sel),
    .a   (pt_a),
    .b   (pt_b),
    .ctl (ctl),
    .q   (q_r)
  );

  mcr_out u_out (
    .cfg_out_reg(cfg_out_reg),
    .cfg_fb_reg (cfg_fb_reg),
    .cfg_oe     (oe_sel_e'(cfg_oe)),
    .q          (q_r),
    .comb       (xor_in),
    .goe0       (goe0),
    .goe1       (goe1),
    .pt_oe      (pt_oe),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .fb_out     (fb_out)
  );

endmodule

// File: rtl/mcr_macrocell_reg_chk.sv
module mcr_macrocell_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cfg_mode,
  input logic [1:0] cfg_dsrc,
  input logic       cfg_clk_pt,
  input logic       cfg_ce_en,
  input logic [1:0] cfg_ar,
  input logic       cfg_ap_en,
  input logic       cfg_out_reg,
  input logic [2:0] cfg_oe,
  input logic       xor_in,
  input logic       pt_d,
  input logic       pin_in,
  input logic       gclk,
  input logic       pt_clk,
  input logic       pt_ce,
  input logic       gclr,
  input logic       pt_ar,
  input logic       pt_ap,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       q_r
);

  logic clr_seen, set_seen, sel_clk, en_ok, dat;

  assign clr_seen = (cfg_ar[0] & gclr) | (cfg_ar[1] & pt_ar);
  assign set_seen = cfg_ap_en & pt_ap;
  assign sel_clk  = cfg_clk_pt ? pt_clk : gclk;
  assign en_ok    = !(cfg_ce_en && !cfg_clk_pt && !pt_ce);
  assign dat      = (cfg_dsrc == 2'd1) ? pt_d : (cfg_dsrc == 2'd2) ? pin_in : xor_in;

  AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_seen |=> (q_r == 1'b0)); // R9

  AST_PRESET_FORCES_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr_seen && set_seen) |=> (q_r == 1'b1)); // R9

  AST_NO_EDGE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    ((cfg_mode < 3'd4) && !clr_seen && !set_seen && !sel_clk) |=> $stable(q_r)); // R6

  AST_ENABLE_LOW_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ((cfg_mode < 3'd4) && !en_ok && !clr_seen && !set_seen) |=> $stable(q_r)); // R8

  AST_LATCH_PASSES: assert property (@(posedge clk) disable iff (rst)
    ((cfg_mode == 3'd4) && sel_clk && en_ok && !clr_seen && !set_seen) |=> (q_r == $past(dat))); // R5

  AST_PAD_FROM_STORE: assert property (@(posedge clk) disable iff (rst)
    cfg_out_reg |-> (pin_out == q_r)); // R10

  AST_OE_FORCED_ON: assert property (@(posedge clk) disable iff (rst)
    (cfg_oe == 3'd0) |-> pin_oe); // R11

  AST_OE_FORCED_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg_oe == 3'd1) |-> !pin_oe); // R11

endmodule

bind mcr_macrocell_reg mcr_macrocell_reg_chk u_chk (.*);

// File: tb/sim_mcr_macrocell_reg.sv
module sim_mcr_macrocell_reg;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_mode = 3'd0;
  logic [1:0] cfg_dsrc = 2'd0;
  logic cfg_clk_pt = 1'b0, cfg_ce_en = 1'b0;
  logic [1:0] cfg_ar = 2'd0;
  logic cfg_ap_en = 1'b0, cfg_out_reg = 1'b1, cfg_fb_reg = 1'b1;
  logic [2:0] cfg_oe = 3'd0;
  logic xor_in = 0, pt_d = 0, pin_in = 0, pt_a = 0, pt_b = 0;
  logic gclk = 0, pt_clk = 0, pt_ce = 0, gclr = 0, pt_ar = 0, pt_ap = 0;
  logic goe0 = 0, goe1 = 0, pt_oe = 0;
  logic pin_out, pin_oe, fb_out;

  always #10 clk = ~clk;

  mcr_macrocell_reg u0 (.*);

  int n_chk = 0, n_bad = 0;
  string cur_req = "R12";
  bit finished = 0;

  // behavioural reference
  int mq = 0, mprev = 0;
  int m_clk, m_gate, m_edge, m_d, m_nq, m_clr;
  always @(posedge clk) begin
    if (rst) begin
      mq = 0; mprev = 0;
    end else begin
      m_clk  = cfg_clk_pt ? pt_clk : gclk;
      m_gate = (cfg_clk_pt || !cfg_ce_en || pt_ce) ? 1 : 0;
      m_edge = (m_clk == 1 && mprev == 0 && m_gate == 1) ? 1 : 0;
      m_d    = (cfg_dsrc == 1) ? pt_d : (cfg_dsrc == 2) ? pin_in : xor_in;
      m_nq   = mq;
      case (cfg_mode)
        0: if (m_edge != 0) m_nq = m_d;
        1: if (m_edge != 0 && m_d != 0) m_nq = 1 - mq;
        2: if (m_edge != 0) begin
             if (pt_a && pt_b) m_nq = 1 - mq;
             else if (pt_a) m_nq = 1;
             else if (pt_b) m_nq = 0;
           end
        3: if (m_edge != 0) begin
             if (pt_a && !pt_b) m_nq = 1;
             else if (pt_b && !pt_a) m_nq = 0;
           end
        4: if (m_clk != 0 && m_gate != 0) m_nq = m_d;
        default: ;
      endcase
      m_clr = ((cfg_ar == 1 && gclr) || (cfg_ar == 2 && pt_ar) || (cfg_ar == 3 && (gclr || pt_ar))) ? 1 : 0;
      if (m_clr != 0) m_nq = 0;
      else if (cfg_ap_en && pt_ap) m_nq = 1;
      mprev = m_clk;
      mq = m_nq;
    end
  end

  task automatic check1(string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    logic e_oe;
    @(posedge clk);
    #5;
    case (cfg_oe)
      0: e_oe = 1'b1;
      2: e_oe = goe0;
      3: e_oe = goe1;
      4: e_oe = pt_oe;
      default: e_oe = 1'b0;
    endcase
    check1("pin_out", pin_out, cfg_out_reg ? mq[0] : xor_in);
    check1("fb_out",  fb_out,  cfg_fb_reg  ? mq[0] : xor_in);
    check1("pin_oe",  pin_oe,  e_oe);
  endtask

  // random stimulus; async lines only when allowed
  task automatic run(int n, bit use_async);
    for (int i = 0; i < n; i++) begin
      xor_in = $urandom_range(1); pt_d = $urandom_range(1); pin_in = $urandom_range(1);
      pt_a = $urandom_range(1); pt_b = $urandom_range(1);
      gclk = $urandom_range(1); pt_clk = $urandom_range(1); pt_ce = $urandom_range(1);
      goe0 = $urandom_range(1); goe1 = $urandom_range(1); pt_oe = $urandom_range(1);
      gclr  = use_async && ($urandom_range(3) == 0);
      pt_ar = use_async && ($urandom_range(3) == 0);
      pt_ap = use_async && ($urandom_range(2) == 0);
      step();
    end
  endtask

  initial begin
    void'($urandom(7));
    // R12: reset state
    cur_req = "R12";
    gclk = 1; xor_in = 1;
    step(); step();
    check1("reset q", pin_out, 1'b0);
    rst = 0;
    gclk = 0; step();

    // R1: D mode over all data sources
    cur_req = "R1";
    for (int s = 0; s < 4; s++) begin cfg_dsrc = s[1:0]; run(24, 0); end
    // R6: held-high and falling clock in D mode
    cur_req = "R6";
    cfg_dsrc = 2'd1;
    gclk = 1; pt_d = 1; step();
    pt_d = 0; step(); step();
    gclk = 0; step();
    run(16, 0);
    // R2 toggle
    cur_req = "R2"; cfg_mode = 3'd1; run(40, 0);
    // R3 JK
    cur_req = "R3"; cfg_mode = 3'd2; run(48, 0);
    // R4 SR
    cur_req = "R4"; cfg_mode = 3'd3; run(48, 0);
    // R5 latch and spare mode codes
    cur_req = "R5"; cfg_mode = 3'd4; run(40, 0);
    for (int m = 5; m < 8; m++) begin cfg_mode = m[2:0]; run(8, 0); end
    // R7 product-term clock
    cur_req = "R7"; cfg_mode = 3'd0; cfg_clk_pt = 1; run(32, 0);
    // R8 enable gating, both clock sources
    cur_req = "R8"; cfg_ce_en = 1; run(32, 0);
    cfg_clk_pt = 0; run(40, 0);
    cfg_mode = 3'd4; run(24, 0);
    cfg_ce_en = 0; cfg_mode = 3'd0;
    // R9 clear/preset sources and priority
    cur_req = "R9";
    for (int a = 0; a < 4; a++) begin
      cfg_ar = a[1:0];
      cfg_ap_en = 0; run(16, 1);
      cfg_ap_en = 1; run(16, 1);
    end
    cfg_ar = 2'd1; gclr = 1; pt_ap = 1; gclk = 0; step();
    check1("clear beats preset", pin_out, 1'b0);
    gclr = 0; pt_ap = 0; step();
    cfg_ar = 2'd0; cfg_ap_en = 0;
    // R10 pad/feedback selection independence
    cur_req = "R10";
    for (int k = 0; k < 4; k++) begin
      cfg_out_reg = k[0]; cfg_fb_reg = k[1]; run(16, 0);
    end
    cfg_out_reg = 1; cfg_fb_reg = 1;
    // R11 output enable selection
    cur_req = "R11";
    for (int o = 0; o < 8; o++) begin cfg_oe = o[2:0]; run(10, 0); end
    // R12 reset again mid-run
    cur_req = "R12";
    cfg_mode = 3'd1; cfg_dsrc = 2'd0; xor_in = 1; gclk = 1;
    rst = 1; step();
    check1("reset mid-run", pin_out, 1'b0);
    rst = 0; gclk = 0; xor_in = 0; step();
    check1("held after reset", pin_out, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule